// File: doc/BRIEF.md
# Two-Stage Interrupt Acknowledge Resolver

This block joins two eight-line priority controllers, a primary and a secondary, into one sixteen-line interrupt system. Each controller reports its current winner (a valid flag and a 3-bit line number) and its programmed vector base. The block drives the single interrupt request to the processor and keeps the primary's cascade input fed. It also answers each acknowledge cycle from the processor with an 8-bit vector and a 4-bit system line number. Register programming and the priority decisions inside each controller lie outside this block.

On an acknowledge, the primary's winner selects the response. Any line other than the cascade line (line 2) is answered directly from the primary. A win on line 2 is resolved through the secondary's winner. When a stage has nothing to offer, line 7 of that stage's base is returned as a spurious vector. Per-controller acknowledge strobes, each with a line number, tell each controller which in-service and request bits to update.

The vector output has no back-pressure. The vector and its valid flag form a one-cycle pulse in the cycle after the acknowledge strobe, and the consumer must take it in that cycle. The acknowledge strobe is a single-cycle pulse per acknowledge, and strobes may arrive back to back.

Top module: `casack_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `cpu_irq_o`, `cas_req_o`, `vec_valid_o`, `mst_ack_o` and `slv_ack_o` are all low.
- R2: While `slv_vld_i` is high, `cas_req_o` alternates high and low on successive cycles, starting high one cycle after `slv_vld_i` is first seen. While `slv_vld_i` is low, `cas_req_o` is low one cycle later.
- R3: Without an acknowledge, `cpu_irq_o` equals `mst_vld_i` one cycle later.
- R4: After an acknowledge is sampled, `cpu_irq_o` is low for the next two cycles. From the third cycle on, it again follows `mst_vld_i`.
- R5: If the primary's winner is a line L other than 2, then one cycle after the acknowledge the outputs are as follows. `vec_o` = {primary base bits 7..3, L}. `irq_num_o` = L. `mst_ack_o` is high with `mst_ack_line_o` = L. `slv_ack_o` is low.
- R6: If the primary wins line 2 and the secondary's winner is line S, then the outputs are as follows. `vec_o` = {secondary base bits 7..3, S}. `irq_num_o` = 8 + S. `mst_ack_o` is high with line 2. `slv_ack_o` is high with `slv_ack_line_o` = S.
- R7: If the primary wins line 2 and the secondary has no winner, then the outputs are as follows. `vec_o` = {secondary base bits 7..3, 7}. `irq_num_o` = 15. The primary is acknowledged on line 2 and `slv_ack_o` stays low.
- R8: If the primary has no winner at acknowledge time, then `vec_o` = {primary base bits 7..3, 7}, `irq_num_o` = 7, and neither acknowledge strobe is raised.
- R9: `vec_valid_o` is high exactly in each cycle that follows a cycle with `ack_i` high. Bits 2..0 of both base inputs never reach `vec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_i | input | 1 | Processor acknowledge strobe, one cycle per acknowledge |
| mst_vld_i | input | 1 | Primary controller has a winner |
| mst_line_i | input | 3 | Primary winner line |
| mst_base_i | input | 8 | Primary vector base byte |
| slv_vld_i | input | 1 | Secondary controller has a winner |
| slv_line_i | input | 3 | Secondary winner line |
| slv_base_i | input | 8 | Secondary vector base byte |
| cpu_irq_o | output | 1 | Interrupt request to the processor |
| cas_req_o | output | 1 | Pulse train to primary cascade input (line 2) |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Returned interrupt vector |
| irq_num_o | output | 4 | System line number 0..15 |
| mst_ack_o | output | 1 | Acknowledge strobe to the primary |
| mst_ack_line_o | output | 3 | Line the primary must acknowledge |
| slv_ack_o | output | 1 | Acknowledge strobe to the secondary |
| slv_ack_line_o | output | 3 | Line the secondary must acknowledge |

## Verification
Two functions can fall in the same cycle: the acknowledge answer and the running request and cascade outputs. An acknowledge arrives while the primary keeps reporting a winner and while the secondary keeps its cascade pulse train going. The bench provokes this by holding both valid inputs high across an acknowledge and across back-to-back acknowledges. A scoreboard then judges each vector against the resolution rules, and the request line is checked low for two cycles and high again on the third.

// File: rtl/casack_pkg.sv
package casack_pkg;
  typedef enum logic [1:0] {
    RES_DIRECT    = 2'd0,
    RES_CASCADE   = 2'd1,
    RES_CASC_SPUR = 2'd2,
    RES_SPUR      = 2'd3
  } res_kind_e;
endpackage

// File: rtl/casack_pulser.sv
module casack_pulser (
  input  logic clk,
  input  logic rst_n,
  input  logic src_vld_i,
  output logic pulse_o
);
  logic pulse_q;
  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= src_vld_i & ~pulse_q;
  end
  assign pulse_o = pulse_q;
endmodule

// File: rtl/casack_irq_gate.sv
module casack_irq_gate #(
  parameter int QUIET_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic want_i,
  output logic irq_o
);
  localparam int CW = $clog2(QUIET_CYCLES + 1);
  logic [CW-1:0] quiet_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ack_i)               quiet_q <= CW'(QUIET_CYCLES - 1);
      else if (quiet_q != '0)  quiet_q <= quiet_q - 1'b1;
      irq_q <= want_i & ~ack_i & (quiet_q == '0);
    end
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/casack_resolver.sv
module casack_resolver
  import casack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2,
  localparam int LINE_W   = $clog2(LINES),
  localparam int NUM_W    = LINE_W + 1
) (
  input  logic              mst_vld_i,
  input  logic [LINE_W-1:0] mst_line_i,
  input  logic [VEC_W-1:0]  mst_base_i,
  input  logic              slv_vld_i,
  input  logic [LINE_W-1:0] slv_line_i,
  input  logic [VEC_W-1:0]  slv_base_i,
  output res_kind_e         kind_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [NUM_W-1:0]  num_o,
  output logic              mst_take_o,
  output logic              slv_take_o
);
  localparam logic [LINE_W-1:0] SPUR = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] CASC = LINE_W'(CASC_LINE);

  always_comb begin
    if (!mst_vld_i)                kind_o = RES_SPUR;
    else if (mst_line_i != CASC)   kind_o = RES_DIRECT;
    else if (slv_vld_i)            kind_o = RES_CASCADE;
    else                           kind_o = RES_CASC_SPUR;
  end

  always_comb begin
    vec_o      = {mst_base_i[VEC_W-1:LINE_W], SPUR};
    num_o      = {1'b0, SPUR};
    mst_take_o = 1'b0;
    slv_take_o = 1'b0;
    unique case (kind_o)
      RES_DIRECT: begin
        vec_o      = {mst_base_i[VEC_W-1:LINE_W], mst_line_i};
        num_o      = {1'b0, mst_line_i};
        mst_take_o = 1'b1;
      end
      RES_CASCADE: begin
        vec_o      = {slv_base_i[VEC_W-1:LINE_W], slv_line_i};
        num_o      = {1'b1, slv_line_i};
        mst_take_o = 1'b1;
        slv_take_o = 1'b1;
      end
      RES_CASC_SPUR: begin
        vec_o      = {slv_base_i[VEC_W-1:LINE_W], SPUR};
        num_o      = {1'b1, SPUR};
        mst_take_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/casack_top.sv
module casack_top
  import casack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2,
  localparam int LINE_W   = $clog2(LINES),
  localparam int NUM_W    = LINE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              mst_vld_i,
  input  logic [LINE_W-1:0] mst_line_i,
  input  logic [VEC_W-1:0]  mst_base_i,
  input  logic              slv_vld_i,
  input  logic [LINE_W-1:0] slv_line_i,
  input  logic [VEC_W-1:0]  slv_base_i,
  output logic              cpu_irq_o,
  output logic              cas_req_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [NUM_W-1:0]  irq_num_o,
  output logic              mst_ack_o,
  output logic [LINE_W-1:0] mst_ack_line_o,
  output logic              slv_ack_o,
  output logic [LINE_W-1:0] slv_ack_line_o
);
  res_kind_e         kind;
  logic [VEC_W-1:0]  res_vec;
  logic [NUM_W-1:0]  res_num;
  logic              mst_take, slv_take;

  casack_pulser u_pulser (
    .clk(clk), .rst_n(rst_n), .src_vld_i(slv_vld_i), .pulse_o(cas_req_o)
  );

  casack_irq_gate #(.QUIET_CYCLES(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .want_i(mst_vld_i), .irq_o(cpu_irq_o)
  );

  casack_resolver #(.LINES(LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) u_res (
    .mst_vld_i(mst_vld_i), .mst_line_i(mst_line_i), .mst_base_i(mst_base_i),
    .slv_vld_i(slv_vld_i), .slv_line_i(slv_line_i), .slv_base_i(slv_base_i),
    .kind_o(kind), .vec_o(res_vec), .num_o(res_num),
    .mst_take_o(mst_take), .slv_take_o(slv_take)
  );

  logic              vld_q, mack_q, sack_q;
  logic [VEC_W-1:0]  vec_q;
  logic [NUM_W-1:0]  num_q;
  logic [LINE_W-1:0] mline_q, sline_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      mack_q  <= 1'b0;
      sack_q  <= 1'b0;
      vec_q   <= '0;
      num_q   <= '0;
      mline_q <= '0;
      sline_q <= '0;
    end else begin
      vld_q  <= ack_i;
      mack_q <= ack_i & mst_take;
      sack_q <= ack_i & slv_take;
      if (ack_i) begin
        vec_q   <= res_vec;
        num_q   <= res_num;
        mline_q <= mst_line_i;
        sline_q <= slv_line_i;
      end
    end
  end

  assign vec_valid_o    = vld_q;
  assign vec_o          = vec_q;
  assign irq_num_o      = num_q;
  assign mst_ack_o      = mack_q;
  assign mst_ack_line_o = mline_q;
  assign slv_ack_o      = sack_q;
  assign slv_ack_line_o = sline_q;
endmodule

// File: rtl/casack_chk.sv
module casack_chk #(
  parameter int LINE_W    = 3,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_i,
  input logic              mst_vld_i,
  input logic              slv_vld_i,
  input logic              cpu_irq_o,
  input logic              cas_req_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              mst_ack_o,
  input logic [LINE_W-1:0] mst_ack_line_o,
  input logic              slv_ack_o,
  input logic [LINE_W-1:0] slv_ack_line_o
);
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o); // R9
  AST_VEC_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_valid_o); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !cpu_irq_o); // R4
  AST_CASC_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    cas_req_o |=> !cas_req_o); // R2
  AST_CASC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_vld_i |=> !cas_req_o); // R2
  AST_SLV_VIA_MST: assert property (@(posedge clk) disable iff (!rst_n)
    slv_ack_o |-> (mst_ack_o && mst_ack_line_o == LINE_W'(CASC_LINE))); // R6
  AST_SLV_VEC_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    slv_ack_o |-> vec_o[LINE_W-1:0] == slv_ack_line_o); // R6
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (!mst_ack_o && !slv_ack_o)); // R8
endmodule

bind casack_top casack_chk #(.LINE_W(LINE_W), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .mst_vld_i(mst_vld_i), .slv_vld_i(slv_vld_i),
  .cpu_irq_o(cpu_irq_o), .cas_req_o(cas_req_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o),
  .mst_ack_o(mst_ack_o), .mst_ack_line_o(mst_ack_line_o),
  .slv_ack_o(slv_ack_o), .slv_ack_line_o(slv_ack_line_o)
);

// File: tb/tb_casack_top.sv
module tb_casack_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] vec;
    logic [3:0] num;
    logic       mack;
    logic [2:0] mline;
    logic       sack;
    logic [2:0] sline;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0;
  logic mv = 1'b0, sv = 1'b0;
  logic [2:0] ml = '0, sl = '0;
  logic [7:0] mb = '0, sb = '0;
  logic cpu_irq, cas_req, vvld, mack, sack;
  logic [7:0] vec;
  logic [3:0] num;
  logic [2:0] mline, sline;
  int n_tests = 0, n_fail = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  casack_top dut (
    .clk(clk), .rst_n(rst_n), .ack_i(ack),
    .mst_vld_i(mv), .mst_line_i(ml), .mst_base_i(mb),
    .slv_vld_i(sv), .slv_line_i(sl), .slv_base_i(sb),
    .cpu_irq_o(cpu_irq), .cas_req_o(cas_req), .vec_valid_o(vvld), .vec_o(vec),
    .irq_num_o(num), .mst_ack_o(mack), .mst_ack_line_o(mline),
    .slv_ack_o(sack), .slv_ack_line_o(sline)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t predict(input string tag);
    exp_t e;
    e.tag = tag; e.mack = 1'b0; e.sack = 1'b0; e.mline = ml; e.sline = sl;
    if (!mv) begin
      e.vec = {mb[7:3], 3'd7}; e.num = 4'd7;
    end else if (ml != 3'd2) begin
      e.vec = {mb[7:3], ml}; e.num = {1'b0, ml}; e.mack = 1'b1;
    end else if (sv) begin
      e.vec = {sb[7:3], sl}; e.num = 4'd8 + {1'b0, sl}; e.mack = 1'b1; e.sack = 1'b1;
    end else begin
      e.vec = {sb[7:3], 3'd7}; e.num = 4'd15; e.mack = 1'b1;
    end
    return e;
  endfunction

  // driver: inputs already set by caller at a negedge; raise ack for one cycle
  task automatic do_ack(input string tag);
    q.push_back(predict(tag));
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && vvld) begin
        exp_t e;
        if (q.size() == 0) begin
          check("R9 unexpected vector", 8'd1, 8'd0);
        end else begin
          e = q.pop_front();
          check({e.tag, " vec"}, vec, e.vec);
          check({e.tag, " num"}, {4'd0, num}, {4'd0, e.num});
          check({e.tag, " mack"}, {7'd0, mack}, {7'd0, e.mack});
          check({e.tag, " sack"}, {7'd0, sack}, {7'd0, e.sack});
          if (e.mack) check({e.tag, " mline"}, {5'd0, mline}, {5'd0, e.mline});
          if (e.sack) check({e.tag, " sline"}, {5'd0, sline}, {5'd0, e.sline});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'd0, cpu_irq}, 8'd0);
    check("R1 vvld in reset", {7'd0, vvld}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {7'd0, cpu_irq}, 8'd0);
    check("R1 cas", {7'd0, cas_req}, 8'd0);
    check("R1 acks", {6'd0, mack, sack}, 8'd0);

    // R3: request follows primary valid
    mv = 1'b1; ml = 3'd4; mb = 8'h27;
    @(negedge clk);
    check("R3 irq high", {7'd0, cpu_irq}, 8'd1);
    mv = 1'b0;
    @(negedge clk);
    check("R3 irq low", {7'd0, cpu_irq}, 8'd0);

    // R2: cascade pulse train
    sv = 1'b1; sl = 3'd5; sb = 8'h71;
    @(negedge clk); check("R2 pulse 1", {7'd0, cas_req}, 8'd1);
    @(negedge clk); check("R2 pulse 0", {7'd0, cas_req}, 8'd0);
    @(negedge clk); check("R2 pulse 1b", {7'd0, cas_req}, 8'd1);
    sv = 1'b0;
    @(negedge clk); check("R2 idle", {7'd0, cas_req}, 8'd0);
    @(negedge clk); check("R2 idle2", {7'd0, cas_req}, 8'd0);

    // R5 and R4: direct, base low bits set (R9)
    mv = 1'b1; ml = 3'd4; mb = 8'h27;
    @(negedge clk);
    do_ack("R5 direct");
    check("R4 irq quiet 1", {7'd0, cpu_irq}, 8'd0);
    @(negedge clk); check("R4 irq quiet 2", {7'd0, cpu_irq}, 8'd0);
    @(negedge clk); check("R4 irq back", {7'd0, cpu_irq}, 8'd1);

    ml = 3'd0; mb = 8'h08; do_ack("R5 line0");
    ml = 3'd7; mb = 8'hFF; do_ack("R5 line7 R9");

    // R6 cascade, secondary active while acks arrive back to back
    sv = 1'b1; ml = 3'd2; sl = 3'd5; sb = 8'h76; mb = 8'h20;
    do_ack("R6 cascade s5");
    sl = 3'd0; do_ack("R6 cascade s0");
    sl = 3'd3; sb = 8'hA9; do_ack("R6 cascade s3");

    // R7 cascade with no secondary winner
    sv = 1'b0; do_ack("R7 casc spur");

    // R8 no primary winner
    mv = 1'b0; mb = 8'h45; do_ack("R8 spur");
    sv = 1'b1; do_ack("R8 spur sv");
    sv = 1'b0;

    @(negedge clk);
    check("R9 no vector idle", {7'd0, vvld}, 8'd0);
    @(negedge clk);
    check("R9 queue drained", 8'(q.size()), 8'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule